// File: doc/BRIEF.md
# Coprocessor Thread Launch Sequencer

This block prepares a small 16-bit RISC coprocessor to run a service thread once a request channel has been granted. The caller gives a channel number, the interrupt priority level of that channel and a relocatable vector table base. The sequencer reads the channel's two-word vector entry from a 64 KB memory through a synchronous read port. The first word goes into the program counter and the second word goes into register R1. R7 is loaded from one of two stack-pointer inputs, and the input is chosen by the priority range. A one-cycle done pulse then tells the core that it may start fetching.

The block also holds the coprocessor's eight-entry register file, in which R0 always reads as zero, and its four-bit condition code register. The core writes the registers, the condition codes and the program counter through simple write ports, and it reads the register file through two combinational read ports. The launch does not touch the condition codes or R2 to R6. Those keep whatever values the running code left in them.

Top module: `thread_launcher`

## Requirements
- R1: After reset, busy, done and mem_re are 0, the program counter is 0x0000 and the condition codes are 0.
- R2: Register 0 always reads as 0x0000 on both read ports, and writes addressed to it have no effect.
- R3: While the sequencer is idle, a core write with wr_en=1 to register 1..7 is visible on the read ports from the next cycle on.
- R4: The vector entry address is vec_base + 4*chan, modulo 2^16. The first word is read at that address and the second word at the address plus 2, modulo 2^16. The two reads have mem_re high on two consecutive cycles, starting the cycle after the start is accepted.
- R5: The first vector word is loaded into the program counter and the second vector word is loaded into R1. Read data returns one cycle after the read is issued.
- R6: R7 is loaded with sp_hi when the accepted priority is 4 to 7, and with sp_lo when it is 1 to 3. The value used is the one sampled on the cycle the start is accepted.
- R7: A launch leaves R2 through R6 and the condition codes unchanged.
- R8: A start with prio = 0 is ignored: busy stays 0, no memory read is issued, and no register changes.
- R9: busy is 1 from the cycle after an accepted start through the done cycle. A start raised while busy is 1 is ignored.
- R10: done is a single-cycle pulse. It appears exactly one cycle after the second vector word returns, which is the fourth cycle after the edge that accepts the start.
- R11: Core writes to the register file, the condition codes or the program counter are ignored while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request for a granted channel |
| chan | input | CH_W | Granted channel number |
| prio | input | 3 | Priority of the channel, 0 = no request |
| vec_base | input | 16 | Vector table base address |
| sp_hi | input | 16 | Stack pointer for priorities 4..7 |
| sp_lo | input | 16 | Stack pointer for priorities 1..3 |
| busy | output | 1 | Launch in progress |
| done | output | 1 | Launch complete, core may fetch |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_rdata | input | 16 | Read data, one cycle after mem_re |
| pc | output | 16 | Program counter |
| pc_we | input | 1 | Core program counter write |
| pc_wdata | input | 16 | Core program counter value |
| ccr | output | 4 | Condition codes {sign, zero, overflow, carry} |
| ccr_we | input | 1 | Core condition code write |
| ccr_wdata | input | 4 | Core condition code value |
| wr_en | input | 1 | Core register write enable |
| wr_sel | input | 3 | Core register write index |
| wr_data | input | 16 | Core register write data |
| rd_sel_a | input | 3 | Read port A index |
| rd_data_a | output | 16 | Read port A data |
| rd_sel_b | input | 3 | Read port B index |
| rd_data_b | output | 16 | Read port B data |

## Verification
The bench builds the block with the default CH_W = 7. With that width the entry offset 4*chan reaches 508. Together with bases drawn near 0xFFFF, this lets the address wrap modulo 2^16 in both vector words. The bench draws priority values across all of 0..7, so the priority-zero filter and both stack-pointer ranges are reached in the same run. Directed launches place a second start, a core register write and a condition code write inside the busy window.

// File: rtl/thread_launcher.sv
module thread_launcher #(
  parameter int CH_W = 7,
  parameter int XW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CH_W-1:0] chan,
  input  logic [2:0]      prio,
  input  logic [XW-1:0]   vec_base,
  input  logic [XW-1:0]   sp_hi,
  input  logic [XW-1:0]   sp_lo,
  output logic            busy,
  output logic            done,
  output logic            mem_re,
  output logic [XW-1:0]   mem_addr,
  input  logic [XW-1:0]   mem_rdata,
  output logic [XW-1:0]   pc,
  input  logic            pc_we,
  input  logic [XW-1:0]   pc_wdata,
  output logic [3:0]      ccr,
  input  logic            ccr_we,
  input  logic [3:0]      ccr_wdata,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [XW-1:0]   wr_data,
  input  logic [2:0]      rd_sel_a,
  output logic [XW-1:0]   rd_data_a,
  input  logic [2:0]      rd_sel_b,
  output logic [XW-1:0]   rd_data_b
);
  localparam int NREG  = 8;
  localparam int ENT_B = 4;
  localparam int DP_IX = 1;
  localparam int SP_IX = NREG - 1;

  typedef enum logic [2:0] {IDLE, FETCH_PC, FETCH_DP, SETTLE, FIN} st_t;

  st_t           st;
  logic [XW-1:0] ent_addr;
  logic [XW-1:0] sp_keep;
  logic [XW-1:0] gpr [NREG];
  logic          accept;
  logic          core_ok;

  assign accept   = start && (prio != 3'd0) && (st == IDLE);
  assign core_ok  = (st == IDLE);
  assign busy     = (st != IDLE);
  assign done     = (st == FIN);
  assign mem_re   = (st == FETCH_PC) || (st == FETCH_DP);
  assign mem_addr = (st == FETCH_DP) ? ent_addr + XW'(2) : ent_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      ent_addr <= '0;
      sp_keep  <= '0;
    end else begin
      unique case (st)
        IDLE: if (accept) begin
          st       <= FETCH_PC;
          ent_addr <= vec_base + XW'(chan) * XW'(ENT_B);
          sp_keep  <= prio[2] ? sp_hi : sp_lo;
        end
        FETCH_PC: st <= FETCH_DP;
        FETCH_DP: st <= SETTLE;
        SETTLE:   st <= FIN;
        FIN:      st <= IDLE;
        default:  st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
    end else if (st == FETCH_DP) begin
      pc <= mem_rdata;
    end else if (core_ok && pc_we) begin
      pc <= pc_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ccr <= '0;
    else if (core_ok && ccr_we) ccr <= ccr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) gpr[i] <= '0;
    end else if (st == SETTLE) begin
      gpr[DP_IX] <= mem_rdata;
      gpr[SP_IX] <= sp_keep;
    end else if (core_ok && wr_en && wr_sel != 3'd0) begin
      gpr[wr_sel] <= wr_data;
    end
  end

  assign rd_data_a = (rd_sel_a == 3'd0) ? '0 : gpr[rd_sel_a];
  assign rd_data_b = (rd_sel_b == 3'd0) ? '0 : gpr[rd_sel_b];
endmodule

module launch_chk #(
  parameter int XW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [2:0]    prio,
  input logic          busy,
  input logic          done,
  input logic          mem_re,
  input logic [XW-1:0] mem_addr,
  input logic [3:0]    ccr,
  input logic [XW-1:0] pc,
  input logic [2:0]    rd_sel_a,
  input logic [XW-1:0] rd_data_a
);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  p_read_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_re) |=> mem_re && (mem_addr == $past(mem_addr) + XW'(2)));
  p_read_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |=> !mem_re);
  p_prio0_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && prio == 3'd0) |=> !busy);
  p_zero_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel_a == 3'd0) |-> (rd_data_a == '0));
  p_ccr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ccr));
  p_done_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

bind thread_launcher launch_chk #(.XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .prio(prio), .busy(busy),
  .done(done), .mem_re(mem_re), .mem_addr(mem_addr), .ccr(ccr), .pc(pc),
  .rd_sel_a(rd_sel_a), .rd_data_a(rd_data_a)
);

// File: tb/sim_thread_launcher.sv
module sim_thread_launcher;
  localparam int CLK_P = 10;
  localparam int CH_W  = 7;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [CH_W-1:0] chan = '0;
  logic [2:0] prio = '0;
  logic [15:0] vec_base = '0, sp_hi = '0, sp_lo = '0;
  logic busy, done, mem_re;
  logic [15:0] mem_addr, mem_rdata, pc;
  logic pc_we = 0; logic [15:0] pc_wdata = '0;
  logic [3:0] ccr; logic ccr_we = 0; logic [3:0] ccr_wdata = '0;
  logic wr_en = 0; logic [2:0] wr_sel = '0; logic [15:0] wr_data = '0;
  logic [2:0] rd_sel_a = '0, rd_sel_b = '0;
  logic [15:0] rd_data_a, rd_data_b;

  int n_vec = 0, n_bad = 0;
  logic [15:0] m_reg [8];
  logic [15:0] m_pc;
  logic [3:0]  m_ccr;

  always #(CLK_P/2) clk = ~clk;

  thread_launcher #(.CH_W(CH_W)) u0 (.*);

  function automatic logic [15:0] memf(input logic [15:0] a);
    logic [15:0] t;
    t = a * 16'h9E37;
    return t ^ 16'h5AC3;
  endfunction

  always_ff @(posedge clk) if (mem_re) mem_rdata <= memf(mem_addr);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < 8; i++) begin
      rd_sel_a = 3'(i); rd_sel_b = 3'(7 - i);
      #1;
      chk(tag, rd_data_a, m_reg[i]);
      chk(tag, rd_data_b, m_reg[7 - i]);
    end
    chk(tag, pc, m_pc);
    chk(tag, {12'd0, ccr}, {12'd0, m_ccr});
  endtask

  task automatic core_write(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
    if (s != 0) m_reg[s] = d;
  endtask

  // disturb: 0 none, 1 second start, 2 core writes while busy
  task automatic launch(input logic [CH_W-1:0] c, input logic [2:0] p,
                        input logic [15:0] b, input int disturb);
    logic [15:0] va;
    @(negedge clk);
    chan = c; prio = p; vec_base = b; start = 1;
    va = b + 16'(c) * 16'd4;
    @(negedge clk); start = 0;
    if (p == 0) begin
      chk("R8 busy", {15'd0, busy}, 16'd0);
      chk("R8 mem_re", {15'd0, mem_re}, 16'd0);
      check_regs("R8 regs");
      return;
    end
    chk("R9 busy", {15'd0, busy}, 16'd1);
    chk("R4 re0", {15'd0, mem_re}, 16'd1);
    chk("R4 addr0", mem_addr, va);
    if (disturb == 1) begin chan = ~c; prio = 3'd5; vec_base = ~b; start = 1; end
    if (disturb == 2) begin
      wr_en = 1; wr_sel = 3'd3; wr_data = ~m_reg[3];
      ccr_we = 1; ccr_wdata = ~m_ccr; pc_we = 1; pc_wdata = 16'hDEAD;
    end
    @(negedge clk);
    chk("R4 re1", {15'd0, mem_re}, 16'd1);
    chk("R4 addr1", mem_addr, va + 16'd2);
    @(negedge clk);
    chk("R5 pc", pc, memf(va));
    chk("R4 re_off", {15'd0, mem_re}, 16'd0);
    chk("R10 early", {15'd0, done}, 16'd0);
    @(negedge clk);
    chk("R10 done", {15'd0, done}, 16'd1);
    chk("R9 busy_done", {15'd0, busy}, 16'd1);
    start = 0; wr_en = 0; ccr_we = 0; pc_we = 0;
    @(negedge clk);
    chk("R10 pulse", {15'd0, done}, 16'd0);
    chk("R9 idle", {15'd0, busy}, 16'd0);
    m_pc = memf(va);
    m_reg[1] = memf(va + 16'd2);
    m_reg[7] = p[2] ? sp_hi : sp_lo;
    check_regs(disturb == 2 ? "R11 regs" : "R5 R6 R7 regs");
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog act=%0d exp=done", n_vec);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234ABCD));
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_pc = '0; m_ccr = '0;
    #(CLK_P * 2 + 3); rst_n = 1;
    @(negedge clk);
    chk("R1 busy", {15'd0, busy}, 16'd0);
    chk("R1 done", {15'd0, done}, 16'd0);
    chk("R1 mem_re", {15'd0, mem_re}, 16'd0);
    check_regs("R1 regs");

    core_write(3'd0, 16'hFFFF);
    check_regs("R2 zero");
    for (int i = 1; i < 8; i++) core_write(3'(i), 16'h1111 * 16'(i));
    check_regs("R3 write");
    @(negedge clk); ccr_we = 1; ccr_wdata = 4'b1010;
    @(negedge clk); ccr_we = 0; m_ccr = 4'b1010;
    chk("R3 ccr", {12'd0, ccr}, 16'h000A);

    sp_hi = 16'hA700; sp_lo = 16'h3100;
    launch(7'd5, 3'd7, 16'h4000, 0);
    launch(7'd9, 3'd2, 16'h4000, 0);
    launch(7'd127, 3'd4, 16'hFFF0, 0);
    launch(7'd0, 3'd1, 16'hFFFE, 0);
    launch(7'd3, 3'd0, 16'h1000, 0);
    launch(7'd12, 3'd6, 16'h2000, 1);
    @(negedge clk);
    chk("R9 no_second", {15'd0, busy}, 16'd0);
    launch(7'd40, 3'd3, 16'h8000, 2);

    for (int k = 0; k < 60; k++) begin
      sp_hi = 16'($urandom); sp_lo = 16'($urandom);
      if ($urandom_range(0, 2) == 0)
        core_write(3'($urandom_range(0, 7)), 16'($urandom));
      launch(CH_W'($urandom), 3'($urandom_range(0, 7)),
             ($urandom_range(0, 1) == 1) ? 16'hFF00 | 16'($urandom_range(0, 255))
                                         : 16'($urandom), 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule